// File: doc/BRIEF.md
# HD Line CRC and Line Number Checker

This block checks the per-line integrity words of a 10-bit high-definition stream that carries two channels in parallel, luma and chroma. Both channels share one set of timing strobes from an upstream timing-reference detector. The block keeps one running CRC per channel across each line. It compares each CRC with the CRC words the line carries after its end-of-active-video code. It also compares the luma line number carried in the stream with the line number supplied by an external timing flywheel.

Each mismatch raises a sticky flag: luma CRC, chroma CRC, or line number. A flag stays high until the host pulses the clear input. If a line ends before all four trailing words have arrived, the line counts as broken and all three flags are raised. In standard-definition mode every check is switched off.

A single sequencer follows the line. Its states are:
- `S_IDLE`: waiting for a start-of-active-video code.
- `S_ACTIVE`: accumulating the CRC.
- `S_LN0`, `S_LN1`: taking the two line-number words.
- `S_CR0`, `S_CR1`: taking the two CRC words.

Its transitions are:
- From `S_IDLE` on a start code to `S_ACTIVE`, which arms the CRC compare.
- From `S_IDLE` on an end code to `S_LN0`, with the CRC compare disarmed.
- From `S_ACTIVE` on an end code to `S_LN0`.
- From each trailing-word state, on a counted word, to the next trailing-word state, and from `S_CR1` to `S_IDLE`.
- From any trailing-word state, on the first word of a new timing code, to `S_IDLE` (the missing-word abort).
- From any state, while standard-definition mode is selected, to `S_IDLE`.

Top module: `hd_line_checker`

## Requirements
- R1: After reset all three error flags read 0.
- R2: The luma CRC is computed as follows. Each word enters an 18-bit register preset to 0 at the start-of-active code, bit 0 first. For every bit, the incoming bit XOR register bit 0 decides whether the right-shifted register is XORed with 0x23000; this is x^18+x^5+x^4+1 in bit-reversed form. The CRC covers every word from the one after the start code through the second line-number word. If it differs from {CR1[8:0], CR0[8:0]}, `y_crc_err` rises on the clock edge that takes CR1.
- R3: The chroma channel is checked the same way with its own register and its own CRC words, and a mismatch raises only `c_crc_err`.
- R4: The trailing words after the end code are, in order: two line-number words, then two CRC words. In the first line-number word, bits 8:2 carry line bits 6:0. In the second, bits 5:2 carry line bits 10:7. The received luma line number is compared with `exp_line` while the second word is taken, and a difference raises `line_err`.
- R5: If the first word of a timing code (`trs_hdr`) arrives before all four trailing words are taken, all three flags rise on that edge.
- R6: Flags are sticky and fall only on `err_clr`. A detection in the same cycle as `err_clr` leaves that flag set, while the other flags clear.
- R7: While `hd_mode` is 0 no flag is set, whatever the data, and the sequencer stays in `S_IDLE`.
- R8: An end code seen in `S_IDLE` (no start code before it) skips both CRC compares but still checks the line number.
- R9: Cycles with `word_en` low are neither fed to the CRCs nor counted as trailing words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hd_mode | input | 1 | 1 = high-definition checks on, 0 = all checks off |
| word_en | input | 1 | A data word is present on both channels this cycle |
| trs_hdr | input | 1 | First word of any timing code |
| trs_sav | input | 1 | Last word of a start-of-active-video code |
| trs_eav | input | 1 | Last word of an end-of-active-video code |
| y_data | input | 10 | Luma word |
| c_data | input | 10 | Chroma word |
| exp_line | input | 11 | Line number from the timing flywheel |
| err_clr | input | 1 | Clears all error flags |
| y_crc_err | output | 1 | Sticky luma CRC error |
| c_crc_err | output | 1 | Sticky chroma CRC error |
| line_err | output | 1 | Sticky line-number error |

## Verification
A host clear and a fresh detection can land on the same clock edge. This is the collision that matters here, because a clear that wins would hide a broken line. The bench first leaves the chroma flag set from an earlier line. It then sends a line with a corrupted luma CRC and raises `err_clr` exactly in the cycle that carries CR1. The expected result is the luma flag set and the chroma flag cleared.

The luma and chroma compares also fall in the same cycle. Corrupting one channel at a time shows that each flag answers only to its own channel.

// File: rtl/hdchk_pkg.sv
package hdchk_pkg;
    localparam int WORD_W   = 10;
    localparam int CRC_W    = 18;
    localparam int LINE_W   = 11;
    localparam int LANES    = 2;
    localparam int LN_LO_W  = 7;
    localparam logic [CRC_W-1:0] CRC_MASK = 18'h23000;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ACTIVE,
        S_LN0,
        S_LN1,
        S_CR0,
        S_CR1
    } seq_state_e;

    function automatic logic [CRC_W-1:0] crc_word(input logic [CRC_W-1:0] cur,
                                                   input logic [WORD_W-1:0] din);
        logic [CRC_W-1:0] r;
        logic fb;
        r = cur;
        for (int i = 0; i < WORD_W; i++) begin
            fb = r[0] ^ din[i];
            r  = r >> 1;
            if (fb) r = r ^ CRC_MASK;
        end
        return r;
    endfunction
endpackage

// File: rtl/hdchk_seq.sv
module hdchk_seq
    import hdchk_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hd_mode,
    input  logic               word_en,
    input  logic               trs_hdr,
    input  logic               trs_sav,
    input  logic               trs_eav,
    input  logic [LN_LO_W-1:0] ln_bits,
    input  logic [LINE_W-1:0]  exp_line,
    output logic               crc_clr,
    output logic               crc_feed,
    output logic               cr0_cap,
    output logic               crc_cmp,
    output logic               ln_mis,
    output logic               miss
);
    localparam int LN_HI_W = LINE_W - LN_LO_W;

    seq_state_e state_q, state_d;
    logic armed_q, armed_d;
    logic [LN_LO_W-1:0] ln0_q;
    logic go, trailing;

    always_comb begin
        state_d = state_q;
        armed_d = armed_q;
        if (!hd_mode) begin
            state_d = S_IDLE;
            armed_d = 1'b0;
        end else if (word_en) begin
            unique case (state_q)
                S_IDLE: begin
                    if (trs_sav) begin
                        state_d = S_ACTIVE;
                        armed_d = 1'b1;
                    end else if (trs_eav) begin
                        state_d = S_LN0;
                        armed_d = 1'b0;
                    end
                end
                S_ACTIVE: if (trs_eav) state_d = S_LN0;
                S_LN0:    state_d = trs_hdr ? S_IDLE : S_LN1;
                S_LN1:    state_d = trs_hdr ? S_IDLE : S_CR0;
                S_CR0:    state_d = trs_hdr ? S_IDLE : S_CR1;
                S_CR1:    state_d = S_IDLE;
                default:  state_d = S_IDLE;
            endcase
            if (state_d == S_IDLE) armed_d = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            armed_q <= 1'b0;
        end else begin
            state_q <= state_d;
            armed_q <= armed_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ln0_q <= '0;
        else if (hd_mode && word_en && state_q == S_LN0)
            ln0_q <= ln_bits;
    end

    always_comb begin
        go       = hd_mode && word_en;
        trailing = (state_q == S_LN0) || (state_q == S_LN1) ||
                   (state_q == S_CR0) || (state_q == S_CR1);
        miss     = go && trailing && trs_hdr;
        crc_clr  = go && trs_sav && (state_q == S_IDLE || state_q == S_ACTIVE);
        crc_feed = go && !trs_sav && !trs_hdr &&
                   (state_q == S_LN0 || state_q == S_LN1);
        if (go && !trs_sav && state_q == S_ACTIVE) crc_feed = 1'b1;
        cr0_cap  = go && !trs_hdr && state_q == S_CR0;
        crc_cmp  = go && !trs_hdr && state_q == S_CR1 && armed_q;
        ln_mis   = go && !trs_hdr && state_q == S_LN1 &&
                   ({ln_bits[LN_HI_W-1:0], ln0_q} != exp_line);
    end

    // R7
    sd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hd_mode |=> state_q == S_IDLE);

    // R5
    abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        miss |=> state_q == S_IDLE && !armed_q);
endmodule

// File: rtl/hdchk_lane.sv
module hdchk_lane
    import hdchk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] data,
    input  logic              crc_clr,
    input  logic              crc_feed,
    input  logic              cr0_cap,
    input  logic              crc_cmp,
    output logic              mis
);
    localparam int HALF_W = CRC_W / 2;

    logic [CRC_W-1:0]  crc_q;
    logic [HALF_W-1:0] cr0_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            crc_q <= '0;
        else if (crc_clr)
            crc_q <= '0;
        else if (crc_feed)
            crc_q <= crc_word(crc_q, data);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cr0_q <= '0;
        else if (cr0_cap)
            cr0_q <= data[HALF_W-1:0];
    end

    assign mis = crc_cmp && ({data[HALF_W-1:0], cr0_q} != crc_q);

    // R9
    crc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!crc_clr && !crc_feed) |=> $stable(crc_q));
endmodule

// File: rtl/hd_line_checker.sv
module hd_line_checker
    import hdchk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hd_mode,
    input  logic              word_en,
    input  logic              trs_hdr,
    input  logic              trs_sav,
    input  logic              trs_eav,
    input  logic [WORD_W-1:0] y_data,
    input  logic [WORD_W-1:0] c_data,
    input  logic [LINE_W-1:0] exp_line,
    input  logic              err_clr,
    output logic              y_crc_err,
    output logic              c_crc_err,
    output logic              line_err
);
    logic crc_clr, crc_feed, cr0_cap, crc_cmp, ln_mis, miss;
    logic [WORD_W-1:0] lane_data [LANES];
    logic [LANES-1:0]  lane_mis;
    logic [2:0] err_q, err_set;

    assign lane_data[0] = y_data;
    assign lane_data[1] = c_data;

    hdchk_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .hd_mode  (hd_mode),
        .word_en  (word_en),
        .trs_hdr  (trs_hdr),
        .trs_sav  (trs_sav),
        .trs_eav  (trs_eav),
        .ln_bits  (y_data[LN_LO_W+1:2]),
        .exp_line (exp_line),
        .crc_clr  (crc_clr),
        .crc_feed (crc_feed),
        .cr0_cap  (cr0_cap),
        .crc_cmp  (crc_cmp),
        .ln_mis   (ln_mis),
        .miss     (miss)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        hdchk_lane u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .data     (lane_data[g]),
            .crc_clr  (crc_clr),
            .crc_feed (crc_feed),
            .cr0_cap  (cr0_cap),
            .crc_cmp  (crc_cmp),
            .mis      (lane_mis[g])
        );
    end

    assign err_set = {ln_mis | miss, lane_mis[1] | miss, lane_mis[0] | miss};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            err_q <= '0;
        else
            err_q <= (err_q & ~{3{err_clr}}) | err_set;
    end

    assign y_crc_err = err_q[0];
    assign c_crc_err = err_q[1];
    assign line_err  = err_q[2];

    // R6
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !err_clr |=> ((err_q & $past(err_q)) == $past(err_q)));

    // R5
    miss_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        miss |=> (err_q == 3'b111));

    // R7
    sd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hd_mode && !err_clr) |=> $stable(err_q));
endmodule

// File: tb/hd_line_checker_bench.sv
module hd_line_checker_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hd_mode = 1'b1, word_en = 1'b0, trs_hdr = 1'b0, trs_sav = 1'b0, trs_eav = 1'b0;
    logic [9:0] y_data = '0, c_data = '0;
    logic [10:0] exp_line = '0;
    logic err_clr = 1'b0;
    logic y_crc_err, c_crc_err, line_err;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [17:0] my_crc, mc_crc;
    bit clr_req = 0;

    always #5 clk = ~clk;

    hd_line_checker u_hd_line_checker (
        .clk(clk), .rst_n(rst_n), .hd_mode(hd_mode), .word_en(word_en),
        .trs_hdr(trs_hdr), .trs_sav(trs_sav), .trs_eav(trs_eav),
        .y_data(y_data), .c_data(c_data), .exp_line(exp_line),
        .err_clr(err_clr), .y_crc_err(y_crc_err), .c_crc_err(c_crc_err),
        .line_err(line_err)
    );

    function automatic logic [17:0] model_crc(input logic [17:0] cur, input logic [9:0] d);
        logic [17:0] r = cur;
        for (int b = 0; b < 10; b++) begin
            logic f = r[0] ^ d[b];
            r = {1'b0, r[17:1]};
            if (f) r = r ^ 18'h23000;
        end
        return r;
    endfunction

    task automatic chk(input string req, input logic [2:0] want);
        logic [2:0] act = {line_err, c_crc_err, y_crc_err};
        checks++;
        if (act !== want) begin
            errors++;
            $display("FAIL %s: flags {line,c,y} actual=%b expected=%b", req, act, want);
        end
    endtask

    task automatic put(input logic [9:0] y, input logic [9:0] c,
                       input logic hdr, input logic sav, input logic eav, input bit feed);
        @(negedge clk);
        word_en = 1'b1; y_data = y; c_data = c;
        trs_hdr = hdr; trs_sav = sav; trs_eav = eav; err_clr = clr_req;
        if (feed) begin
            my_crc = model_crc(my_crc, y);
            mc_crc = model_crc(mc_crc, c);
        end
    endtask

    task automatic idle();
        @(negedge clk);
        word_en = 1'b0; trs_hdr = 1'b0; trs_sav = 1'b0; trs_eav = 1'b0; err_clr = 1'b0;
    endtask

    task automatic clear_flags();
        @(negedge clk); word_en = 1'b0; err_clr = 1'b1;
        @(negedge clk); err_clr = 1'b0;
    endtask

    // post: number of trailing words sent before a new timing code cuts in (4 = complete)
    task automatic send_line(input bit with_sav, input int nact, input int seed,
                             input logic [10:0] rx_line, input logic [10:0] want_line,
                             input bit bad_y, input bit bad_c, input bit gaps,
                             input bit clr_cr1, input int post);
        logic [9:0] ln0, ln1, ycr0, ycr1, ccr0, ccr1;
        exp_line = want_line;
        if (with_sav) begin
            put(10'h3FF, 10'h3FF, 1, 0, 0, 0);
            put(10'h000, 10'h000, 0, 0, 0, 0);
            put(10'h000, 10'h000, 0, 0, 0, 0);
            put(10'h200, 10'h200, 0, 1, 0, 0);
            my_crc = '0; mc_crc = '0;
        end
        for (int i = 0; i < nact; i++) begin
            put(10'((seed * 61 + i * 29 + 5) & 10'h3FF),
                10'((seed * 17 + i * 83 + 11) & 10'h3FF), 0, 0, 0, 1);
            if (gaps && (i % 2 == 0)) idle();
        end
        put(10'h3FF, 10'h3FF, 1, 0, 0, 1);
        put(10'h000, 10'h000, 0, 0, 0, 1);
        put(10'h000, 10'h000, 0, 0, 0, 1);
        put(10'h274, 10'h274, 0, 0, 1, 1);
        ln0 = {~rx_line[6], rx_line[6:0], 2'b00};
        ln1 = {1'b1, 3'b000, rx_line[10:7], 2'b00};
        if (post > 0) begin put(ln0, 10'h040, 0, 0, 0, 1); if (gaps) idle(); end
        if (post > 1) begin put(ln1, 10'h200, 0, 0, 0, 1); if (gaps) idle(); end
        ycr0 = {~my_crc[8], my_crc[8:0]};  ycr1 = {~my_crc[17], my_crc[17:9]};
        ccr0 = {~mc_crc[8], mc_crc[8:0]};  ccr1 = {~mc_crc[17], mc_crc[17:9]};
        if (bad_y) ycr0[0] = ~ycr0[0];
        if (bad_c) ccr1[3] = ~ccr1[3];
        if (post > 2) begin put(ycr0, ccr0, 0, 0, 0, 0); if (gaps) idle(); end
        if (post > 3) begin
            clr_req = clr_cr1;
            put(ycr1, ccr1, 0, 0, 0, 0);
            clr_req = 0;
        end else begin
            put(10'h3FF, 10'h3FF, 1, 0, 0, 0);
        end
        idle();
    endtask

    task automatic t_reset();
        #1 chk("R1 during reset", 3'b000);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 after reset", 3'b000);
    endtask

    task automatic t_clean();
        send_line(1, 12, 1, 11'd42, 11'd42, 0, 0, 0, 0, 4);
        chk("R2 R3 R4 clean line", 3'b000);
        send_line(1, 3, 9, 11'd1, 11'd1, 0, 0, 0, 0, 4);
        chk("R2 R3 short clean line", 3'b000);
    endtask

    task automatic t_bad_y();
        clear_flags();
        send_line(1, 10, 2, 11'd100, 11'd100, 1, 0, 0, 0, 4);
        chk("R2 luma CRC mismatch", 3'b001);
    endtask

    task automatic t_bad_c();
        clear_flags();
        send_line(1, 10, 3, 11'd200, 11'd200, 0, 1, 0, 0, 4);
        chk("R3 chroma CRC mismatch", 3'b010);
    endtask

    task automatic t_bad_line();
        clear_flags();
        send_line(1, 8, 4, 11'd300, 11'd301, 0, 0, 0, 0, 4);
        chk("R4 line number low bits", 3'b100);
        clear_flags();
        send_line(1, 8, 5, 11'h7FF, 11'h7FF, 0, 0, 0, 0, 4);
        chk("R4 line number all ones matches", 3'b000);
        send_line(1, 8, 6, 11'h07F, 11'h47F, 0, 0, 0, 0, 4);
        chk("R4 line number bit 10 differs", 3'b100);
    endtask

    task automatic t_sticky();
        clear_flags();
        send_line(1, 6, 7, 11'd5, 11'd5, 1, 0, 0, 0, 4);
        send_line(1, 6, 8, 11'd6, 11'd6, 0, 0, 0, 0, 4);
        chk("R6 flag held over a clean line", 3'b001);
        clear_flags();
        chk("R6 flag cleared by err_clr", 3'b000);
    endtask

    task automatic t_missing();
        clear_flags();
        send_line(1, 6, 10, 11'd20, 11'd20, 0, 0, 0, 0, 2);
        chk("R5 CRC words missing", 3'b111);
        clear_flags();
        send_line(1, 6, 11, 11'd21, 11'd21, 0, 0, 0, 0, 0);
        chk("R5 all trailing words missing", 3'b111);
        clear_flags();
    endtask

    task automatic t_sd();
        clear_flags();
        hd_mode = 1'b0;
        send_line(1, 6, 12, 11'd30, 11'd31, 1, 1, 0, 0, 4);
        chk("R7 SD mode corrupt line", 3'b000);
        send_line(1, 6, 13, 11'd30, 11'd30, 0, 0, 0, 0, 1);
        chk("R7 SD mode truncated line", 3'b000);
        hd_mode = 1'b1;
    endtask

    task automatic t_unarmed();
        clear_flags();
        send_line(0, 4, 14, 11'd77, 11'd77, 1, 1, 0, 0, 4);
        chk("R8 no start code, CRC not compared", 3'b000);
        send_line(0, 4, 15, 11'd77, 11'd78, 0, 0, 0, 0, 4);
        chk("R8 no start code, line still compared", 3'b100);
    endtask

    task automatic t_gaps();
        clear_flags();
        send_line(1, 9, 16, 11'd500, 11'd500, 0, 0, 1, 0, 4);
        chk("R9 idle cycles ignored", 3'b000);
        send_line(1, 9, 17, 11'd501, 11'd501, 0, 1, 1, 0, 4);
        chk("R9 idle cycles, chroma error still found", 3'b010);
    endtask

    task automatic t_collide();
        clear_flags();
        send_line(1, 5, 18, 11'd9, 11'd9, 0, 1, 0, 0, 4);
        chk("R6 setup chroma flag", 3'b010);
        send_line(1, 5, 19, 11'd10, 11'd10, 1, 0, 0, 1, 4);
        chk("R6 clear and detect same cycle", 3'b001);
    endtask

    initial begin
        t_reset();
        t_clean();
        t_bad_y();
        t_bad_c();
        t_bad_line();
        t_sticky();
        t_missing();
        t_sd();
        t_unarmed();
        t_gaps();
        t_collide();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule